// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This block adds or subtracts two 32-bit floating-point words and returns a 32-bit word in the same format. A positive value is packed as a zero top bit, an 8-bit exponent field biased by 128, and a 23-bit fraction that sits below an implied leading one. A negative value is the 32-bit two's-complement negation of the packed positive word. An exponent field of zero means the value is zero, whatever its fraction bits.

A one-cycle `start` pulse captures `op_a`, `op_b` and `sub_mode`. The unit works for a variable number of cycles and then raises `done` for one cycle, with the result word or an error. It unpacks both operands and shifts the operand with the smaller exponent right, one place per cycle. It then adds or subtracts the 32-bit magnitudes and corrects the sign on a borrow. After that it normalizes to the left, using a 16-place step while the upper half is empty, and finally rounds and packs. An exponent that overflows the field raises an error. An exponent that underflows quietly yields zero.

Top module: `fas_addsub`

## Requirements
- R1: A word with bit 31 set is unpacked as the negation of its 32-bit two's complement. Bits 30:23 of the magnitude hold the exponent biased by 128, and a field of 0 means zero. The working mantissa is {1, bits 22:0, eight zero bits}. The result is packed the same way and negated when the result sign is negative. `result` holds its value between `done` pulses.
- R2: With `sub_mode` 0 the result is a+b, and with 1 it is a−b. The magnitudes are added when (sign_a XOR sign_b XOR sub_mode) is 0 and subtracted (a minus b) otherwise. The result sign starts as sign_a.
- R3: When the exponents differ, the operand with the smaller exponent is shifted right one bit per cycle until the exponents match. When the difference is more than 31, its mantissa is cleared instead.
- R4: When either mantissa is zero, no alignment takes place. When `op_a` is the zero one, the exponent of `op_b` is used.
- R5: A carry out of the magnitude addition shifts the sum right one place, sets bit 31, and raises the exponent by one.
- R6: A borrow out of the magnitude subtraction negates the 32-bit difference and inverts the result sign.
- R7: A nonzero mantissa is shifted left until bit 31 is set. While bits 31:16 are all zero, the step moves 16 places at once. The exponent drops by the total shift.
- R8: A zero magnitude result gives `result` = 0x00000000 with no error.
- R9: When the low 8 mantissa bits are 0x80 or more, 0x100 is added before packing. A carry out of bit 31 shifts the mantissa right with bit 31 set and raises the exponent by one.
- R10: When the final unbiased exponent is above 127, `err` rises with `done`, `err_code` is 2 and `result` is 0.
- R11: When the biased exponent is below 0, `result` is 0 and `err` stays low.
- R12: `done` is a one-cycle pulse, one for each accepted `start`. A `start` that arrives while an operation is in progress is ignored. `err` is high only together with `done`. After reset `done`, `err` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation with the current operands |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| sub_mode | input | 1 | 0: a+b, 1: a−b |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result word, held until the next completion |
| err | output | 1 | Error, valid with `done` |
| err_code | output | 4 | Error code (2 = exponent overflow) |

## Verification
The hardest cases to reach are a rounding carry that runs out of bit 31 and exponents that leave the field at either end. Random operands almost never produce them. The stimulus builds them on purpose. An all-ones fraction meets an addend placed exactly 24 places lower, so the round-up ripples through. The largest magnitude is doubled to force the overflow code. Two minimum-exponent values that differ by one unit of the last place are cancelled, so normalization drives the exponent below the bias. A sweep then pairs operands whose exponents differ by a few places and whose fractions are often equal, so alignment, cancellation and the 16-place step are all exercised.

// File: rtl/fas_pkg.sv
package fas_pkg;
   localparam int unsigned FAS_CODE_W = 4;
   localparam logic [FAS_CODE_W-1:0] FAS_CODE_NONE     = 4'd0;
   localparam logic [FAS_CODE_W-1:0] FAS_CODE_EXP_HIGH = 4'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_OP,
      ST_NORM,
      ST_PACK
   } fas_state_e;
endpackage

// File: rtl/fas_unpack.sv
module fas_unpack #(
   parameter int unsigned W  = 32,
   parameter int unsigned EW = 8,
   parameter int unsigned EI = EW + 3
) (
   input  logic [W-1:0]          word_i,
   output logic                  neg_o,
   output logic signed [EI-1:0]  exp_o,
   output logic [W-1:0]          mant_o
);
   localparam int unsigned FW = W - 1 - EW;
   localparam logic signed [EI-1:0] BIAS_S = EI'(1 << (EW - 1));

   logic [W-1:0]  mag;
   logic [EW-1:0] fld;

   always_comb begin
      neg_o = word_i[W-1];
      mag   = word_i[W-1] ? -word_i : word_i;
      fld   = mag[W-2 -: EW];
      if (fld == '0) begin
         exp_o  = '0;
         mant_o = '0;
      end else begin
         exp_o  = $signed({{(EI-EW){1'b0}}, fld}) - BIAS_S;
         mant_o = {1'b1, mag[FW-1:0], {EW{1'b0}}};
      end
   end
endmodule

// File: rtl/fas_magop.sv
module fas_magop #(
   parameter int unsigned W  = 32,
   parameter int unsigned EI = 11
) (
   input  logic [W-1:0]          ma_i,
   input  logic [W-1:0]          mb_i,
   input  logic signed [EI-1:0]  exp_i,
   input  logic                  sa_i,
   input  logic                  sb_i,
   input  logic                  mode_i,
   output logic [W-1:0]          mant_o,
   output logic signed [EI-1:0]  exp_o,
   output logic                  neg_o
);
   localparam logic signed [EI-1:0] ONE_E = EI'(1);

   logic         eff_sub;
   logic [W:0]   sum;
   logic [W:0]   dif;

   always_comb begin
      eff_sub = sa_i ^ sb_i ^ mode_i;
      sum     = {1'b0, ma_i} + {1'b0, mb_i};
      dif     = {1'b0, ma_i} - {1'b0, mb_i};
      mant_o  = sum[W-1:0];
      exp_o   = exp_i;
      neg_o   = sa_i;
      if (!eff_sub) begin
         if (sum[W]) begin
            mant_o = {1'b1, sum[W-1:1]};
            exp_o  = exp_i + ONE_E;
         end
      end else begin
         if (dif[W]) begin
            mant_o = -dif[W-1:0];
            neg_o  = ~sa_i;
         end else begin
            mant_o = dif[W-1:0];
         end
      end
   end
endmodule

// File: rtl/fas_pack.sv
module fas_pack #(
   parameter int unsigned W  = 32,
   parameter int unsigned EW = 8,
   parameter int unsigned EI = EW + 3
) (
   input  logic [W-1:0]          mant_i,
   input  logic signed [EI-1:0]  exp_i,
   input  logic                  neg_i,
   output logic [W-1:0]          word_o,
   output logic                  ovf_o
);
   localparam logic signed [EI-1:0] BIAS_S = EI'(1 << (EW - 1));
   localparam logic signed [EI-1:0] MAX_B  = EI'((1 << EW) - 1);
   localparam logic signed [EI-1:0] ONE_E  = EI'(1);
   localparam logic signed [EI-1:0] ZERO_E = '0;

   logic [W:0]          rsum;
   logic [W-1:0]        mn;
   logic signed [EI-1:0] en;
   logic signed [EI-1:0] biased;
   logic [W-1:0]        pos;

   always_comb begin
      rsum   = {1'b0, mant_i} + ({{W{1'b0}}, mant_i[EW-1]} << EW);
      mn     = rsum[W-1:0];
      en     = exp_i;
      if (rsum[W]) begin
         mn = rsum[W:1];
         en = exp_i + ONE_E;
      end
      biased = en + BIAS_S;
      pos    = {1'b0, biased[EW-1:0], mn[W-2:EW]};
      ovf_o  = 1'b0;
      word_o = '0;
      if (!mant_i[W-1]) begin
         word_o = '0;
      end else if (biased > MAX_B) begin
         ovf_o  = 1'b1;
      end else if (biased < ZERO_E) begin
         word_o = '0;
      end else begin
         word_o = neg_i ? -pos : pos;
      end
   end
endmodule

// File: rtl/fas_addsub.sv
module fas_addsub
   import fas_pkg::*;
#(
   parameter int unsigned W         = 32,
   parameter int unsigned EW        = 8,
   parameter bit          FAST_NORM = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [W-1:0]          op_a,
   input  logic [W-1:0]          op_b,
   input  logic                  sub_mode,
   output logic                  done,
   output logic [W-1:0]          result,
   output logic                  err,
   output logic [FAS_CODE_W-1:0] err_code
);
   localparam int unsigned EI   = EW + 3;
   localparam int unsigned CW   = $clog2(W);
   localparam int unsigned HALF = W / 2;
   localparam logic signed [EI-1:0] MAX_SH = EI'(W - 1);
   localparam logic signed [EI-1:0] ZERO_E = '0;
   localparam logic signed [EI-1:0] ONE_E  = EI'(1);
   localparam logic signed [EI-1:0] HALF_E = EI'(HALF);
   localparam logic [CW-1:0]        CNT_ONE = CW'(1);

   if ((W % 2) != 0 || EW < 2 || (W - 1 - EW) < 2 || EW > 16) begin : g_bad_cfg
      $error("fas_addsub: unsupported width configuration");
   end

   fas_state_e           state_q;
   logic [W-1:0]         ma_q, mb_q, acc_q;
   logic signed [EI-1:0] ea_q, e_q;
   logic                 sa_q, sb_q, mode_q, sign_q, sel_a_q;
   logic [CW-1:0]        cnt_q;

   logic                 ua_s, ub_s;
   logic signed [EI-1:0] ua_e, ub_e, diff_ba, diff_ab;
   logic [W-1:0]         ua_m, ub_m;
   logic [W-1:0]         op_m, nrm_acc, pk_word;
   logic signed [EI-1:0] op_e, nrm_e;
   logic                 op_s, pk_ovf;

   fas_unpack #(.W(W), .EW(EW), .EI(EI)) u_unp_a (
      .word_i(op_a), .neg_o(ua_s), .exp_o(ua_e), .mant_o(ua_m));
   fas_unpack #(.W(W), .EW(EW), .EI(EI)) u_unp_b (
      .word_i(op_b), .neg_o(ub_s), .exp_o(ub_e), .mant_o(ub_m));

   fas_magop #(.W(W), .EI(EI)) u_mag (
      .ma_i(ma_q), .mb_i(mb_q), .exp_i(ea_q), .sa_i(sa_q), .sb_i(sb_q),
      .mode_i(mode_q), .mant_o(op_m), .exp_o(op_e), .neg_o(op_s));

   fas_pack #(.W(W), .EW(EW), .EI(EI)) u_pack (
      .mant_i(acc_q), .exp_i(e_q), .neg_i(sign_q),
      .word_o(pk_word), .ovf_o(pk_ovf));

   assign diff_ba = ub_e - ua_e;
   assign diff_ab = ua_e - ub_e;

   if (FAST_NORM) begin : g_leap
      always_comb begin
         if (acc_q[W-1:HALF] == '0) begin
            nrm_acc = acc_q << HALF;
            nrm_e   = e_q - HALF_E;
         end else begin
            nrm_acc = acc_q << 1;
            nrm_e   = e_q - ONE_E;
         end
      end
   end else begin : g_bitwise
      always_comb begin
         nrm_acc = acc_q << 1;
         nrm_e   = e_q - ONE_E;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ma_q     <= '0;
         mb_q     <= '0;
         acc_q    <= '0;
         ea_q     <= '0;
         e_q      <= '0;
         sa_q     <= 1'b0;
         sb_q     <= 1'b0;
         mode_q   <= 1'b0;
         sign_q   <= 1'b0;
         sel_a_q  <= 1'b0;
         cnt_q    <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         result   <= '0;
         err_code <= FAS_CODE_NONE;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ma_q    <= ua_m;
                  mb_q    <= ub_m;
                  ea_q    <= ua_e;
                  sa_q    <= ua_s;
                  sb_q    <= ub_s;
                  mode_q  <= sub_mode;
                  state_q <= ST_OP;
                  if (ua_m == '0 || ub_m == '0) begin
                     if (ua_m == '0) ea_q <= ub_e;
                  end else if (diff_ba > ZERO_E) begin
                     ea_q <= ub_e;
                     if (diff_ba > MAX_SH) begin
                        ma_q <= '0;
                     end else begin
                        cnt_q   <= diff_ba[CW-1:0];
                        sel_a_q <= 1'b1;
                        state_q <= ST_ALIGN;
                     end
                  end else if (diff_ab > ZERO_E) begin
                     if (diff_ab > MAX_SH) begin
                        mb_q <= '0;
                     end else begin
                        cnt_q   <= diff_ab[CW-1:0];
                        sel_a_q <= 1'b0;
                        state_q <= ST_ALIGN;
                     end
                  end
               end
            end
            ST_ALIGN: begin
               if (sel_a_q) ma_q <= ma_q >> 1;
               else         mb_q <= mb_q >> 1;
               cnt_q <= cnt_q - CNT_ONE;
               if (cnt_q == CNT_ONE) state_q <= ST_OP;
            end
            ST_OP: begin
               acc_q   <= op_m;
               e_q     <= op_e;
               sign_q  <= op_s;
               state_q <= ST_NORM;
            end
            ST_NORM: begin
               if (acc_q == '0 || acc_q[W-1]) begin
                  state_q <= ST_PACK;
               end else begin
                  acc_q <= nrm_acc;
                  e_q   <= nrm_e;
               end
            end
            ST_PACK: begin
               done     <= 1'b1;
               err      <= pk_ovf;
               result   <= pk_ovf ? '0 : pk_word;
               err_code <= pk_ovf ? FAS_CODE_EXP_HIGH : FAS_CODE_NONE;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fas_addsub_chk.sv
module fas_addsub_chk
   import fas_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  done,
   input logic                  err,
   input logic [FAS_CODE_W-1:0] err_code,
   input logic [W-1:0]          result
);
   localparam logic [W-1:0] MIN_WORD = {1'b1, {(W-1){1'b0}}};

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else if (done) pend_q <= start;
      else if (start) pend_q <= 1'b1;
   end

   assert_done_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend_q);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && err_code == FAS_CODE_EXP_HIGH));

   assert_err_zero_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> result == '0);

   assert_result_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   assert_no_min_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result != MIN_WORD);
endmodule

bind fas_addsub fas_addsub_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done),
   .err(err), .err_code(err_code), .result(result));

// File: tb/sim_fas_addsub.sv
module sim_fas_addsub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        sub_mode = 1'b0;
   logic        done;
   logic [31:0] result;
   logic        err;
   logic [3:0]  err_code;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [31:0] seed = 32'h1234_5679;

   always #5 clk = ~clk;

   fas_addsub u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .sub_mode(sub_mode), .done(done), .result(result), .err(err),
      .err_code(err_code));

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // Arithmetic model of the requirements; returns {err, word}
   function automatic logic [32:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                          input logic md);
      logic [31:0] ma, mb, m, mag, w;
      logic        sa, sb, sg;
      logic [32:0] t;
      int ea, eb, d, bx;
      sa = a[31]; mag = sa ? -a : a;
      if (mag[30:23] == 8'd0) begin ma = 0; ea = 0; end
      else begin ma = {1'b1, mag[22:0], 8'h00}; ea = int'(mag[30:23]) - 128; end
      sb = b[31]; mag = sb ? -b : b;
      if (mag[30:23] == 8'd0) begin mb = 0; eb = 0; end
      else begin mb = {1'b1, mag[22:0], 8'h00}; eb = int'(mag[30:23]) - 128; end
      if (ma == 0 || mb == 0) begin
         if (ma == 0) ea = eb;
      end else if (ea < eb) begin
         d = eb - ea; ea = eb; ma = (d > 31) ? 32'd0 : (ma >> d);
      end else if (eb < ea) begin
         d = ea - eb; mb = (d > 31) ? 32'd0 : (mb >> d);
      end
      sg = sa;
      if ((sa ^ sb ^ md) == 1'b0) begin
         t = {1'b0, ma} + {1'b0, mb};
         if (t[32]) begin m = {1'b1, t[31:1]}; ea = ea + 1; end
         else m = t[31:0];
      end else begin
         t = {1'b0, ma} - {1'b0, mb};
         if (t[32]) begin m = -t[31:0]; sg = ~sg; end
         else m = t[31:0];
      end
      if (m == 0) return 33'd0;
      while (!m[31]) begin m = m << 1; ea = ea - 1; end
      if (m[7]) begin
         t = {1'b0, m} + 33'h100;
         if (t[32]) begin m = t[32:1]; ea = ea + 1; end
         else m = t[31:0];
      end
      bx = ea + 128;
      if (bx > 255) return {1'b1, 32'd0};
      if (bx < 0) return 33'd0;
      w = {1'b0, bx[7:0], m[30:8]};
      return {1'b0, sg ? -w : w};
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic md,
                         output logic [31:0] r, output logic e, output logic [3:0] c);
      int n = 0;
      @(negedge clk);
      op_a = a; op_b = b; sub_mode = md; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL R12: done missing, got 0 expected 1");
      end
      r = result; e = err; c = err_code;
   endtask

   task automatic expect_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                            input logic md, input logic [31:0] exp_w, input logic exp_e);
      logic [31:0] r;
      logic e;
      logic [3:0] c;
      run_op(a, b, md, r, e, c);
      check(tag, {31'd0, e, r}, {31'd0, exp_e, exp_w});
      if (exp_e) check({tag, " code"}, {60'd0, c}, 64'd2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r1, r2, pa, pb, a, b;
      logic [7:0]  fb;
      logic [22:0] frb;
      logic [32:0] ex;
      logic [31:0] first_r;
      int ndone;

      repeat (3) @(negedge clk);
      check("R12 reset done/err/result", {31'd0, done, err, result}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 idle after reset", {31'd0, done, err, result}, 64'd0);

      // R1 / R5: 1.0 + 1.0 = 2.0, and negated forms
      expect_op("R5 1+1 carry", 32'h4000_0000, 32'h4000_0000, 1'b0, 32'h4080_0000, 1'b0);
      expect_op("R1 -1+-1", 32'hC000_0000, 32'hC000_0000, 1'b0, 32'hBF80_0000, 1'b0);
      expect_op("R1 -1+3", 32'hC000_0000, 32'h40C0_0000, 1'b0, 32'h4080_0000, 1'b0);
      // R2: effective operation from signs and mode
      expect_op("R2 1-(-1)", 32'h4000_0000, 32'hC000_0000, 1'b1, 32'h4080_0000, 1'b0);
      expect_op("R2 R8 1-1", 32'h4000_0000, 32'h4000_0000, 1'b1, 32'h0000_0000, 1'b0);
      expect_op("R8 -1+1", 32'hC000_0000, 32'h4000_0000, 1'b0, 32'h0000_0000, 1'b0);
      // R3: alignment both directions and flush beyond 31 places
      expect_op("R3 1+0.5", 32'h4000_0000, 32'h3F80_0000, 1'b0, 32'h4040_0000, 1'b0);
      expect_op("R3 0.5+1", 32'h3F80_0000, 32'h4000_0000, 1'b0, 32'h4040_0000, 1'b0);
      expect_op("R3 flush b", 32'h4000_0000, 32'h3000_0000, 1'b0, 32'h4000_0000, 1'b0);
      expect_op("R3 flush a", 32'h3000_0000, 32'h4000_0000, 1'b0, 32'h4000_0000, 1'b0);
      // R4: zero operands
      expect_op("R4 0+3", 32'h0000_0000, 32'h40C0_0000, 1'b0, 32'h40C0_0000, 1'b0);
      expect_op("R4 3+0", 32'h40C0_0000, 32'h0000_0000, 1'b0, 32'h40C0_0000, 1'b0);
      expect_op("R4 R6 0-3", 32'h0000_0000, 32'h40C0_0000, 1'b1, 32'hBF40_0000, 1'b0);
      // R6 / R7: borrow, normalization with and without the 16-place step
      expect_op("R6 1-2", 32'h4000_0000, 32'h4080_0000, 1'b1, 32'hC000_0000, 1'b0);
      expect_op("R7 1.5-1", 32'h4040_0000, 32'h4000_0000, 1'b1, 32'h3F80_0000, 1'b0);
      expect_op("R7 leap cancel", 32'h4000_0000, 32'h4000_0001, 1'b1, 32'hCB80_0000, 1'b0);
      // R9: rounding threshold and rounding carry
      expect_op("R9 round up", 32'h4000_0000, 32'h3400_0000, 1'b0, 32'h4000_0001, 1'b0);
      expect_op("R9 below half", 32'h4000_0000, 32'h3380_0000, 1'b0, 32'h4000_0000, 1'b0);
      expect_op("R9 round carry", 32'h407F_FFFF, 32'h3400_0000, 1'b0, 32'h4080_0000, 1'b0);
      // R10 / R11: exponent range
      expect_op("R10 overflow add", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 32'h0, 1'b1);
      expect_op("R10 overflow sub", 32'h7FFF_FFFF, 32'h8000_0001, 1'b1, 32'h0, 1'b1);
      expect_op("R11 underflow", 32'h0080_0001, 32'h0080_0000, 1'b1, 32'h0, 1'b0);

      // R12: start during an operation is ignored
      @(negedge clk);
      op_a = 32'h4000_0000; op_b = 32'h4000_0000; sub_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      op_a = 32'h40C0_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ndone = 0; first_r = '0;
      for (int k = 0; k < 100; k++) begin
         if (done) begin
            if (ndone == 0) first_r = result;
            ndone++;
         end
         @(negedge clk);
      end
      check("R12 busy start ignored count", 64'(ndone), 64'd1);
      check("R12 busy start ignored value", {32'd0, first_r}, {32'd0, 32'h4080_0000});

      // Sweep against the arithmetic model (R2 R3 R6 R7 R9)
      for (int i = 0; i < 600; i++) begin
         seed = nxt(seed); r1 = seed;
         seed = nxt(seed); r2 = seed;
         pa  = {1'b0, r1[30:0]};
         a   = r1[31] ? -pa : pa;
         fb  = r1[30:23] + {{5{r2[3]}}, r2[2:0]};
         frb = r2[4] ? r1[22:0] : r2[31:9];
         pb  = {1'b0, fb, frb};
         b   = r2[5] ? -pb : pb;
         ex  = ref_op(a, b, r2[6]);
         expect_op("R2 sweep", a, b, r2[6], ex[31:0], ex[32]);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule